// File: doc/BRIEF.md
# Parallel Vertical-Counter Switch Debouncer

This block filters a bank of mechanical switches in parallel. Each switch owns one bit in each of several shared counter bit-planes. The planes form a ripple increment, so every switch is counted by one column of bits, and all columns are processed in the same cycle. A common tick strobe, nominally one per millisecond, paces all work. A one-hot ring prescaler picks which switch may count on each tick, so every switch is sampled once every eight ticks. Any switch that reads released on a tick loses its count and its debounced state at once.

When a switch has been seen pressed on four of its own sample slots, its debounced bit sets. A pending-press latch turns that rising edge into a new-press event. The event lasts one tick period, toggles a flag bit that the consumer may clear, and starts a short beep on a speaker pin. If a held switch has its repeat-enable bit set, a carry out of the top counter plane every 64 counts knocks its pending latch back. The held switch then produces a fresh press event every 512 ticks.

Raw inputs are expected to be already synchronous to the clock.

Top module: `swdeb_vc`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the debounced level, press pulses, flags, the beep counter and the speaker pin. It also reloads the prescaler so that the first tick after reset serves switch 0.
- R2: The k-th tick after reset (k counted from 0) lets only switch k mod 8 advance its counter. A pressed switch at any other position keeps its count on that tick.
- R3: On any tick where a switch's raw bit is 0 (released), its count returns to zero and its debounced bit reads 0 after that tick.
- R4: A switch held pressed (raw bit 1) gets its debounced bit set on the tick of its fourth consecutive counting slot. The bit stays set for as long as the switch stays pressed.
- R5: A `press_evt` bit is 1 for exactly one tick period, starting at the tick where that switch's debounced bit rises from 0 to 1, or at a repeat event (R6).
- R6: While a switch stays pressed and its `rpt_en` bit is 1 at the tick, each 64th count of that switch produces a new press event. Counting from the first pressed slot, these fall on counts 64, 128 and so on, which is every 512 ticks. With `rpt_en` at 0, no repeat event is produced.
- R7: Each press event inverts the matching bit of `flags`.
- R8: A 1 on a `flag_clr` bit clears that flag on the next clock edge, whether or not a tick is present. It wins over a toggle of the same bit in the same cycle.
- R9: Any press event ORs 32 into the beep counter. On each tick where the counter (after that OR) is nonzero, `spk` inverts and the counter decrements. A single press therefore gives 32 toggles, a 500 Hz tone at a 1 ms tick.
- R10: With `tick` low, the debounced level, press pulses and speaker do not change. Flags change only through `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe, nominally 1 ms period |
| sw_raw | input | 8 | Raw switch state, 1 = pressed |
| rpt_en | input | 8 | Per-switch auto-repeat enable |
| flag_clr | input | 8 | Per-switch flag clear strobe |
| deb_level | output | 8 | Debounced switch level |
| press_evt | output | 8 | New-press events, valid for one tick period |
| flags | output | 8 | Toggle flags for the consumer |
| spk | output | 1 | Piezo speaker drive |

## Verification
The bench holds one switch long enough to hit the exact ticks of the first press and of two repeats. A design that took the debounce carry from the wrong plane, rotated the prescaler the wrong way, or repeated on the wrong count would move these events off ticks 27, 507 and 1019. A flag clear placed on the same cycle as a repeat toggle catches a design that lets the toggle win. Random bouncing, with its fast release-and-repress runs, catches a design that keeps stale counts or a stale pending latch across a release. A single press followed by silence checks that the speaker toggles exactly 32 times, which exposes an off-by-one in the beep counter. Every cycle is also compared against an integer-count model, so a design that changes state between ticks is caught.

// File: rtl/swdeb_pkg.sv
package swdeb_pkg;
  localparam int unsigned SWDEB_DEF_SW       = 8;
  localparam int unsigned SWDEB_DEF_DEB_PL   = 2;
  localparam int unsigned SWDEB_DEF_RPT_PL   = 4;
  localparam int unsigned SWDEB_DEF_BEEP_BIT = 5;

  // Rotate the low w bits of v left by one place.
  function automatic logic [31:0] ring_advance(input logic [31:0] v, input int unsigned w);
    logic [31:0] m;
    m = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
    return ((v << 1) | (v >> (w - 1))) & m;
  endfunction
endpackage

// File: rtl/swdeb_colring.sv
module swdeb_colring
  import swdeb_pkg::*;
#(
  parameter int unsigned N_SW = SWDEB_DEF_SW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [N_SW-1:0] col_hot
);
  localparam logic [N_SW-1:0] COL_SEED = N_SW'(1);

  logic [N_SW-1:0] col_next;

  always_comb begin
    col_next = N_SW'(ring_advance(32'(col_hot), N_SW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_hot <= COL_SEED;
    end else if (tick) begin
      col_hot <= col_next;
    end
  end
endmodule

// File: rtl/swdeb_vplanes.sv
module swdeb_vplanes #(
  parameter int unsigned N_SW      = 8,
  parameter int unsigned DEB_PLANES = 2,
  parameter int unsigned RPT_PLANES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [N_SW-1:0] sw,
  input  logic [N_SW-1:0] col,
  output logic [N_SW-1:0] deb_q,
  output logic [N_SW-1:0] deb_next,
  output logic [N_SW-1:0] deb_carry,
  output logic [N_SW-1:0] rpt_carry
);
  localparam int unsigned PLANES = DEB_PLANES + RPT_PLANES;

  logic [N_SW-1:0] pl_q    [PLANES];
  logic [N_SW-1:0] pl_n    [PLANES];
  logic [N_SW-1:0] pl_held [PLANES];

  // Ripple increment across bit-planes: each plane flips under the running
  // carry mask, and the mask survives only where that plane was already 1.
  always_comb begin
    logic [N_SW-1:0] run;
    run       = sw & col;
    deb_carry = '0;
    for (int k = 0; k < int'(PLANES); k++) begin
      pl_held[k] = pl_q[k] & sw;
      pl_n[k]    = pl_held[k] ^ run;
      run        = run & pl_held[k];
      if (k == int'(DEB_PLANES) - 1) begin
        deb_carry = run;
      end
    end
    rpt_carry = run;
  end

  assign deb_next = (deb_q & sw) | deb_carry;

  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    always_ff @(posedge clk) begin
      if (rst) begin
        pl_q[g] <= '0;
      end else if (tick) begin
        pl_q[g] <= pl_n[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deb_q <= '0;
    end else if (tick) begin
      deb_q <= deb_next;
    end
  end
endmodule

// File: rtl/swdeb_press.sv
module swdeb_press #(
  parameter int unsigned N_SW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [N_SW-1:0] deb_next,
  input  logic [N_SW-1:0] rpt_carry,
  input  logic [N_SW-1:0] rpt_en,
  input  logic [N_SW-1:0] flag_clr,
  output logic [N_SW-1:0] press_q,
  output logic [N_SW-1:0] flags_q,
  output logic [N_SW-1:0] new_evt,
  output logic [N_SW-1:0] rpt_fire
);
  logic [N_SW-1:0] pend_q;
  logic [N_SW-1:0] pend_t;

  // Clear wins over toggle.
  function automatic logic [N_SW-1:0] flag_update(input logic [N_SW-1:0] cur,
                                                  input logic [N_SW-1:0] tog,
                                                  input logic [N_SW-1:0] clr);
    return (cur ^ tog) & ~clr;
  endfunction

  assign rpt_fire = tick ? (rpt_carry & rpt_en) : '0;
  assign pend_t   = pend_q ^ rpt_fire;
  assign new_evt  = tick ? (deb_next & ~pend_t) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      press_q <= '0;
      flags_q <= '0;
    end else begin
      if (tick) begin
        pend_q  <= deb_next;
        press_q <= new_evt;
      end
      flags_q <= flag_update(flags_q, new_evt, flag_clr);
    end
  end
endmodule

// File: rtl/swdeb_beep.sv
module swdeb_beep #(
  parameter int unsigned BEEP_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              trig,
  output logic              spk,
  output logic [BEEP_BIT:0] beep_cnt
);
  localparam int unsigned BW = BEEP_BIT + 1;
  localparam logic [BW-1:0] LOAD_BIT = BW'(1) << BEEP_BIT;

  logic [BW-1:0] loaded;
  logic          active;

  function automatic logic [BW-1:0] beep_load(input logic [BW-1:0] cnt, input logic t);
    return t ? (cnt | LOAD_BIT) : cnt;
  endfunction

  assign loaded = beep_load(beep_cnt, trig);
  assign active = (loaded != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      beep_cnt <= '0;
      spk      <= 1'b0;
    end else if (tick) begin
      if (active) begin
        spk      <= ~spk;
        beep_cnt <= loaded - BW'(1);
      end else begin
        beep_cnt <= loaded;
      end
    end
  end
endmodule

// File: rtl/swdeb_vc.sv
module swdeb_vc
  import swdeb_pkg::*;
#(
  parameter int unsigned N_SW       = SWDEB_DEF_SW,
  parameter int unsigned DEB_PLANES = SWDEB_DEF_DEB_PL,
  parameter int unsigned RPT_PLANES = SWDEB_DEF_RPT_PL,
  parameter int unsigned BEEP_BIT   = SWDEB_DEF_BEEP_BIT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [N_SW-1:0] sw_raw,
  input  logic [N_SW-1:0] rpt_en,
  input  logic [N_SW-1:0] flag_clr,
  output logic [N_SW-1:0] deb_level,
  output logic [N_SW-1:0] press_evt,
  output logic [N_SW-1:0] flags,
  output logic            spk
);
  logic [N_SW-1:0]   col_hot;
  logic [N_SW-1:0]   deb_next;
  logic [N_SW-1:0]   deb_carry;
  logic [N_SW-1:0]   rpt_carry;
  logic [N_SW-1:0]   new_evt;
  logic [N_SW-1:0]   rpt_fire;
  logic              any_new;
  logic [BEEP_BIT:0] beep_cnt;

  swdeb_colring #(.N_SW(N_SW)) u_ring (
    .clk(clk), .rst(rst), .tick(tick), .col_hot(col_hot)
  );

  swdeb_vplanes #(.N_SW(N_SW), .DEB_PLANES(DEB_PLANES), .RPT_PLANES(RPT_PLANES)) u_planes (
    .clk(clk), .rst(rst), .tick(tick), .sw(sw_raw), .col(col_hot),
    .deb_q(deb_level), .deb_next(deb_next), .deb_carry(deb_carry), .rpt_carry(rpt_carry)
  );

  swdeb_press #(.N_SW(N_SW)) u_press (
    .clk(clk), .rst(rst), .tick(tick), .deb_next(deb_next), .rpt_carry(rpt_carry),
    .rpt_en(rpt_en), .flag_clr(flag_clr), .press_q(press_evt), .flags_q(flags),
    .new_evt(new_evt), .rpt_fire(rpt_fire)
  );

  assign any_new = |new_evt;

  swdeb_beep #(.BEEP_BIT(BEEP_BIT)) u_beep (
    .clk(clk), .rst(rst), .tick(tick), .trig(any_new), .spk(spk), .beep_cnt(beep_cnt)
  );
endmodule

// File: rtl/swdeb_vc_chk.sv
module swdeb_vc_chk #(
  parameter int unsigned N_SW     = 8,
  parameter int unsigned BEEP_BIT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [N_SW-1:0]   sw_raw,
  input logic [N_SW-1:0]   flag_clr,
  input logic [N_SW-1:0]   deb_level,
  input logic [N_SW-1:0]   press_evt,
  input logic [N_SW-1:0]   flags,
  input logic              spk,
  input logic              any_new,
  input logic [BEEP_BIT:0] beep_cnt,
  input logic [N_SW-1:0]   col_hot
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (deb_level == '0 && press_evt == '0 && flags == '0 && spk == 1'b0 && beep_cnt == '0));

  // R2
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(col_hot) == 1);

  // R3
  release_clears_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((deb_level & ~$past(sw_raw)) == '0));

  // R5
  press_needs_level_chk: assert property (@(posedge clk) disable iff (rst)
    (press_evt & ~deb_level) == '0);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|flag_clr) |=> ((flags & $past(flag_clr)) == '0));

  // R9
  beep_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && beep_cnt != '0) |=> (spk != $past(spk)));

  // R9
  beep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && beep_cnt == '0 && !any_new) |=> $stable(spk));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(deb_level) && $stable(press_evt) && $stable(spk)));
endmodule

bind swdeb_vc swdeb_vc_chk #(.N_SW(N_SW), .BEEP_BIT(BEEP_BIT)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sw_raw(sw_raw), .flag_clr(flag_clr),
  .deb_level(deb_level), .press_evt(press_evt), .flags(flags), .spk(spk),
  .any_new(any_new), .beep_cnt(beep_cnt), .col_hot(col_hot)
);

// File: tb/test_swdeb_vc.sv
`timescale 1ns/1ps
module test_swdeb_vc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] sw_raw = '0, rpt_en = '0, flag_clr = '0;
  logic [7:0] deb_level, press_evt, flags;
  logic       spk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model
  int         cnt_m [8];
  logic [7:0] deb_m, pend_m, press_m, flags_m;
  int         beep_m;
  logic       spk_m;
  int         col_m;
  int         tick_idx;

  always #5 clk = ~clk;

  swdeb_vc i_swdeb_vc (
    .clk(clk), .rst(rst), .tick(tick), .sw_raw(sw_raw), .rpt_en(rpt_en),
    .flag_clr(flag_clr), .deb_level(deb_level), .press_evt(press_evt),
    .flags(flags), .spk(spk)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) cnt_m[i] = 0;
    deb_m = '0; pend_m = '0; press_m = '0; flags_m = '0;
    beep_m = 0; spk_m = 1'b0; col_m = 0; tick_idx = 0;
  endfunction

  // Integer-count restatement of the requirements.
  function automatic void model_edge(input logic tk, input logic [7:0] s,
                                     input logic [7:0] r, input logic [7:0] c);
    logic [7:0] fire, newp, pt;
    int b;
    fire = '0;
    newp = '0;
    if (tk) begin
      for (int i = 0; i < 8; i++) begin
        if (!s[i]) begin
          cnt_m[i] = 0;        // R3
          deb_m[i] = 1'b0;
        end else if (i == col_m) begin   // R2
          cnt_m[i] = (cnt_m[i] + 1) % 64;
          if (cnt_m[i] % 4 == 0) deb_m[i] = 1'b1;  // R4
          if (cnt_m[i] == 0) fire[i] = 1'b1;       // R6
        end
      end
      pt      = pend_m ^ (fire & r);
      newp    = deb_m & ~pt;
      pend_m  = deb_m;
      press_m = newp;
      b = beep_m | ((newp != 0) ? 32 : 0);
      if (b != 0) begin
        spk_m = ~spk_m;
        b = b - 1;
      end
      beep_m = b;
      col_m = (col_m + 1) % 8;
      tick_idx++;
    end
    flags_m = (flags_m ^ newp) & ~c;   // R7, R8
  endfunction

  task automatic step(input logic tk, input logic [7:0] s, input logic [7:0] r, input logic [7:0] c);
    tick = tk; sw_raw = s; rpt_en = r; flag_clr = c;
    @(posedge clk);
    model_edge(tk, s, r, c);
    @(negedge clk);
    chk("R4", "deb_level", 32'(deb_level), 32'(deb_m));
    chk("R5", "press_evt", 32'(press_evt), 32'(press_m));
    chk("R7", "flags", 32'(flags), 32'(flags_m));
    chk("R9", "spk", 32'(spk), 32'(spk_m));
  endtask

  // one tick followed by three quiet cycles (R10 covered by the quiet ones)
  task automatic tick_step(input logic [7:0] s, input logic [7:0] r, input logic [7:0] c);
    step(1'b1, s, r, c);
    for (int q = 0; q < 3; q++) step(1'b0, s, r, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int press_ticks [$];
    int spk_toggles;
    logic [7:0] s, r;
    logic spk_prev;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "deb_level", 32'(deb_level), 0);
    chk("R1", "press_evt", 32'(press_evt), 0);
    chk("R1", "flags", 32'(flags), 0);
    chk("R1", "spk", 32'(spk), 0);

    // R2 R4 R6: switch 3 held with repeat enabled; presses at ticks 27, 507, 1019.
    for (int t = 0; t < 1030; t++) begin
      int idx;
      idx = tick_idx;
      // R8: clear flag 3 on the same cycle as the tick-1019 repeat toggle
      tick_step(8'h08, 8'h08, (idx == 1019) ? 8'h08 : 8'h00);
      if (press_evt[3]) press_ticks.push_back(idx);
      if (idx == 1019) begin
        chk("R8", "flag3 after clear+toggle", 32'(flags[3]), 0);
        chk("R6", "press3 on repeat tick", 32'(press_evt[3]), 1);
      end
    end
    chk("R6", "press count with repeat", press_ticks.size(), 3);
    if (press_ticks.size() == 3) begin
      chk("R4", "first press tick", press_ticks[0], 27);
      chk("R6", "first repeat tick", press_ticks[1], 507);
      chk("R6", "second repeat tick", press_ticks[2], 1019);
    end

    // R3: release clears level on that tick
    tick_step(8'h00, 8'h08, 8'h00);
    chk("R3", "deb3 after release", 32'(deb_level[3]), 0);

    // let the beep finish, then R9: single press gives exactly 32 toggles
    for (int t = 0; t < 40; t++) tick_step(8'h00, 8'h00, 8'h00);
    spk_toggles = 0;
    press_ticks.delete();
    for (int t = 0; t < 90; t++) begin
      spk_prev = spk;
      tick_step(8'h01, 8'h00, 8'h00);
      if (spk != spk_prev) spk_toggles++;
    end
    chk("R9", "toggles for one press", spk_toggles, 32);

    // R6 negative: switch 5 held 600 ticks with repeat disabled -> one press
    tick_step(8'h00, 8'h00, 8'h00);
    for (int t = 0; t < 600; t++) begin
      tick_step(8'h20, 8'h00, 8'h00);
      if (press_evt[5]) press_ticks.push_back(t);
    end
    chk("R6", "press count without repeat", press_ticks.size(), 1);

    // Random bouncing, repeat masks and clears, all checked against the model.
    void'($urandom(32'd20240611));
    s = '0;
    r = 8'h5a;
    for (int t = 0; t < 5000; t++) begin
      logic [7:0] c;
      for (int i = 0; i < 8; i++) begin
        if (($urandom % 150) == 0) s[i] = ~s[i];
      end
      if (($urandom % 40) == 0) s = s ^ 8'($urandom);   // bounce burst
      if (($urandom % 400) == 0) r = 8'($urandom);
      c = (($urandom % 12) == 0) ? 8'($urandom) : 8'h00;
      step(1'b1, s, r, c);
      step(1'b0, s, r, (($urandom % 20) == 0) ? 8'($urandom) : 8'h00);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule